// File: doc/BRIEF.md
# Eight-Line Priority Interrupt Controller

The block gathers eight interrupt request lines into a single interrupt output for a processor. It holds three eight-bit registers: pending requests, lines currently in service, and a per-line mask. When the processor pulses the acknowledge input, the controller chooses the winning line, marks it in service, and returns a vector. The vector is a programmable base plus the line number. A write-only command tells the controller that the handler has finished. That command frees the in-service line with the highest priority.

Four priority schemes are available, selected by a register write. Fixed nested priority gives line 0 the top rank. In rotating priority, each finished line drops to the bottom. In special mask mode, lines already in service stop blocking lines ranked below them. In polled mode the interrupt output stays low, and the processor reads a status word that also acts as the acknowledge. Each input can be edge- or level-sensitive. When an acknowledge finds no eligible request, the controller returns a fallback vector.

Top module: `prio_intc`

## Requirements
- R1: After reset the pending, in-service and mask registers are zero, the block is in nested mode with edge-sensitive inputs and base 0, and `int_out` is low.
- R2: When `ack` is sampled high outside polled mode with an eligible winner, `vec_valid` pulses on the next cycle with `vec_out` = base + line. The winner's in-service bit is set at that edge. Nested mode ranks line 0 first and line 7 last.
- R3: A set mask bit stops its line from raising `int_out` and from winning an acknowledge. Clearing the bit lets a latched request through again.
- R4: In nested and rotating modes, `int_out` is high only when an unmasked pending line ranks above every in-service line.
- R5: A write to address 3 with data bit 0 set is an end-of-interrupt command. It clears the in-service bit of the highest-ranked in-service line.
- R6: Mode code 01 (mode field is write-data bits 2:1 at address 1) selects rotating priority. There, an end-of-interrupt makes the freed line the lowest rank, and the line after it becomes the highest. The initial ordering is the nested one.
- R7: Mode code 10 selects special mask mode. There, in-service lines are not candidates and do not gate others. A lower line can interrupt while a higher one is in service.
- R8: Mode code 11 selects polled mode. In this mode `int_out` stays low and `ack` produces no vector. A read of address 0 returns bit 7 set plus the line number in bits 2:0, and acknowledges that line. With nothing pending the read returns 0.
- R9: If `ack` finds no eligible request, `vec_out` = base + 7 and no in-service bit changes.
- R10: Address 1 bit 0 selects the trigger mode. When it is 0 (edge), a pending bit latches on a rising input and clears when acknowledged. When it is 1 (level), the pending bit copies its input each cycle.
- R11: Writes: address 0 sets the base, address 1 sets trigger and mode, address 2 sets the mask. Reads: address 1 returns pending, address 2 returns in-service, address 3 returns mask. Read data appears with `rd_valid` one cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Request lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data |
| rd_valid | output | 1 | Read data valid |
| int_out | output | 1 | Interrupt request to the processor |
| ack | input | 1 | Interrupt acknowledge pulse |
| vec_out | output | 8 | Returned vector |
| vec_valid | output | 1 | Vector valid pulse |

## Verification
The assertions assume three things about the inputs: `ack` is a single-cycle pulse, reads and writes never happen on the same cycle as a mode change they depend on, and `rst_n` is held for at least one clock. The stimulus drives every strobe for exactly one cycle from tasks. It changes modes only between complete request, acknowledge and end-of-interrupt sequences. It lowers request lines before raising them again, so that edge-sensitive inputs see clean rising edges.

// File: rtl/prio_intc.sv
module prio_intc (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] irq_in,
  input  logic       wr_en,
  input  logic [1:0] wr_addr,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic [1:0] rd_addr,
  output logic [7:0] rd_data,
  output logic       rd_valid,
  output logic       int_out,
  input  logic       ack,
  output logic [7:0] vec_out,
  output logic       vec_valid
);
  localparam logic [1:0] M_NEST = 2'd0, M_ROT = 2'd1, M_SMASK = 2'd2, M_POLL = 2'd3;

  logic [7:0] base_q, mask_q, irr_q, isr_q, irq_q;
  logic [1:0] mode_q;
  logic       level_q;
  logic [2:0] ptr_q;

  function automatic logic [3:0] pick(input logic [7:0] v, input logic [2:0] low);
    logic [3:0] r;
    logic [2:0] idx;
    r = 4'd0;
    for (int i = 0; i < 8; i++) begin
      idx = low + 3'd1 + 3'(i);
      if (!r[3] && v[idx]) r = {1'b1, idx};
    end
    return r;
  endfunction

  function automatic logic [2:0] rank(input logic [2:0] line, input logic [2:0] low);
    return line - low - 3'd1;
  endfunction

  logic [2:0] low_eff;
  logic [7:0] cand;
  logic [3:0] win, svc, pwin;
  logic       win_ok, ack_fire, poll_fire, eoi_fire, take_any;
  logic [2:0] take_line;
  logic [7:0] set_bits, clr_bits, rise;

  assign low_eff  = (mode_q == M_ROT) ? ptr_q : 3'd7;
  assign cand     = irr_q & ~mask_q & ((mode_q == M_SMASK) ? ~isr_q : 8'hFF);
  assign win      = pick(cand, low_eff);
  assign svc      = pick(isr_q, low_eff);
  assign pwin     = pick(irr_q & ~mask_q, low_eff);
  assign win_ok   = win[3] && (mode_q == M_SMASK || !svc[3] ||
                    rank(win[2:0], low_eff) < rank(svc[2:0], low_eff));
  assign int_out  = win_ok && (mode_q != M_POLL);

  assign ack_fire  = ack && (mode_q != M_POLL);
  assign poll_fire = rd_en && (rd_addr == 2'd0) && (mode_q == M_POLL);
  assign eoi_fire  = wr_en && (wr_addr == 2'd3) && wr_data[0];

  assign take_any  = (ack_fire && win_ok) || (poll_fire && pwin[3]);
  assign take_line = ack_fire ? win[2:0] : pwin[2:0];
  assign set_bits  = take_any ? (8'b1 << take_line) : 8'd0;
  assign clr_bits  = (eoi_fire && svc[3]) ? (8'b1 << svc[2:0]) : 8'd0;
  assign rise      = irq_in & ~irq_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q    <= 8'd0;
      mode_q    <= M_NEST;
      level_q   <= 1'b0;
      mask_q    <= 8'd0;
      irr_q     <= 8'd0;
      isr_q     <= 8'd0;
      irq_q     <= 8'd0;
      ptr_q     <= 3'd7;
      vec_out   <= 8'd0;
      vec_valid <= 1'b0;
      rd_data   <= 8'd0;
      rd_valid  <= 1'b0;
    end else begin
      irq_q <= irq_in;
      irr_q <= level_q ? irq_in : ((irr_q | rise) & ~set_bits);
      isr_q <= (isr_q & ~clr_bits) | set_bits;

      if (wr_en) begin
        case (wr_addr)
          2'd0: base_q <= wr_data;
          2'd1: begin level_q <= wr_data[0]; mode_q <= wr_data[2:1]; end
          2'd2: mask_q <= wr_data;
          default: ;
        endcase
      end
      if (eoi_fire && svc[3] && mode_q == M_ROT) ptr_q <= svc[2:0];

      vec_valid <= ack_fire;
      if (ack_fire) vec_out <= base_q + {5'd0, (win_ok ? win[2:0] : 3'd7)};

      rd_valid <= rd_en;
      if (rd_en) begin
        case (rd_addr)
          2'd0: rd_data <= (mode_q == M_POLL) ? {pwin[3], 4'd0, pwin[2:0]} : 8'd0;
          2'd1: rd_data <= irr_q;
          2'd2: rd_data <= isr_q;
          default: rd_data <= mask_q;
        endcase
      end
    end
  end

  a_r2_isr_needs_ack: assert property (@(posedge clk) disable iff (!rst_n)
    ((isr_q & ~$past(isr_q)) != 8'd0) |-> $past(ack_fire || poll_fire));

  a_r2_vec_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> $past(ack));

  a_r3_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    int_out |-> ((irr_q & ~mask_q) != 8'd0));

  a_r4_nested_rank: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_NEST && int_out && isr_q != 8'd0) |-> ((irr_q & ~mask_q & ((8'b1 << svc[2:0]) - 8'd1)) != 8'd0));

  a_r5_eoi_clears_one: assert property (@(posedge clk) disable iff (!rst_n)
    (eoi_fire && isr_q != 8'd0 && !ack_fire && !poll_fire) |=>
      ($countones(isr_q) + 1 == $countones($past(isr_q))));

  a_r9_spurious_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !win_ok && !eoi_fire) |=>
      (isr_q == $past(isr_q) && vec_out == $past(base_q) + 8'd7));

  a_r8_poll_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == M_POLL && $past(mode_q) == M_POLL) |-> !vec_valid);
endmodule

// File: tb/prio_intc_test.sv
module prio_intc_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] irq_in = 8'd0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic       rd_en = 1'b0;
  logic [1:0] rd_addr = 2'd0;
  logic [7:0] rd_data, vec_out;
  logic       rd_valid, int_out, vec_valid;
  logic       ack = 1'b0;

  int total = 0;
  int bad = 0;
  logic [7:0] vq[$];
  string      vtag[$];
  logic [7:0] rq[$];
  string      rtag[$];

  always #2.5 clk = ~clk;

  prio_intc uut (.clk(clk), .rst_n(rst_n), .irq_in(irq_in), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid),
    .int_out(int_out), .ack(ack), .vec_out(vec_out), .vec_valid(vec_valid));

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && vec_valid) begin
      if (vq.size() == 0) chk(1'b0, "R8 unexpected vector", vec_out, 8'h00);
      else begin
        automatic logic [7:0] e = vq.pop_front();
        automatic string t = vtag.pop_front();
        chk(vec_out == e, t, vec_out, e);
      end
    end
    if (rst_n && rd_valid) begin
      if (rq.size() == 0) chk(1'b0, "R11 unexpected read", rd_data, 8'h00);
      else begin
        automatic logic [7:0] e = rq.pop_front();
        automatic string t = rtag.pop_front();
        chk(rd_data == e, t, rd_data, e);
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic eoi();
    wreg(2'd3, 8'h01);
  endtask

  task automatic do_ack(input logic [7:0] e, input string t);
    vq.push_back(e); vtag.push_back(t);
    ack = 1'b1;
    cyc(1);
    ack = 1'b0;
  endtask

  task automatic do_rd(input logic [1:0] a, input logic [7:0] e, input string t);
    rq.push_back(e); rtag.push_back(t);
    rd_en = 1'b1; rd_addr = a;
    cyc(1);
    rd_en = 1'b0;
  endtask

  task automatic chk_int(input bit e, input string t);
    chk(int_out == e, t, {7'd0, int_out}, {7'd0, e});
  endtask

  initial begin
    #1000000;
    chk(1'b0, "watchdog", 8'h00, 8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    chk_int(1'b0, "R1 int low after reset");
    do_rd(2'd1, 8'h00, "R1 pending zero");
    do_rd(2'd2, 8'h00, "R1 in-service zero");
    do_rd(2'd3, 8'h00, "R1 mask zero");
    wreg(2'd0, 8'h20);

    irq_in = 8'h24; cyc(1);
    chk_int(1'b1, "R2 int raised");
    do_ack(8'h22, "R2 vector line 2 first");
    do_rd(2'd2, 8'h04, "R2 isr line 2");
    do_rd(2'd1, 8'h20, "R10 edge bit cleared on ack");
    chk_int(1'b0, "R4 lower line gated");
    eoi();
    do_rd(2'd2, 8'h00, "R5 eoi clears");
    chk_int(1'b1, "R4 int after eoi");
    do_ack(8'h25, "R2 vector line 5");
    irq_in = 8'h26; cyc(1);
    chk_int(1'b1, "R4 higher line preempts");
    do_ack(8'h21, "R4 vector line 1");
    do_rd(2'd2, 8'h22, "R2 isr lines 1 and 5");
    eoi();
    do_rd(2'd2, 8'h20, "R5 highest in-service cleared");
    eoi();
    irq_in = 8'h00; cyc(1);
    chk_int(1'b0, "R10 edge does not relatch");

    wreg(2'd2, 8'h08);
    irq_in = 8'h08; cyc(1);
    chk_int(1'b0, "R3 masked line silent");
    do_ack(8'h27, "R9 fallback vector");
    do_rd(2'd2, 8'h00, "R9 isr unchanged");
    do_rd(2'd1, 8'h08, "R3 request still latched");
    wreg(2'd2, 8'h00);
    chk_int(1'b1, "R3 unmask releases");
    do_ack(8'h23, "R3 vector line 3");
    eoi();
    irq_in = 8'h00; cyc(1);

    wreg(2'd1, 8'h01);
    irq_in = 8'h10; cyc(1);
    chk_int(1'b1, "R10 level raises");
    irq_in = 8'h00; cyc(1);
    chk_int(1'b0, "R10 level follows input");
    do_ack(8'h27, "R9 vanished request");
    do_rd(2'd2, 8'h00, "R9 no isr set");
    irq_in = 8'h40; cyc(1);
    do_rd(2'd1, 8'h40, "R10 level pending");
    do_ack(8'h26, "R10 level vector");
    do_rd(2'd1, 8'h40, "R10 level stays after ack");
    do_rd(2'd2, 8'h40, "R10 level isr");
    irq_in = 8'h00;
    eoi();
    wreg(2'd1, 8'h00);

    wreg(2'd1, 8'h02);
    irq_in = 8'h05; cyc(1);
    do_ack(8'h20, "R6 initial order line 0");
    chk_int(1'b0, "R6 line 2 gated");
    eoi();
    do_ack(8'h22, "R6 vector line 2");
    eoi();
    irq_in = 8'h00; cyc(1);
    irq_in = 8'h09; cyc(1);
    do_ack(8'h23, "R6 line 3 outranks line 0");
    eoi();
    do_ack(8'h20, "R6 line 0 after rotation");
    eoi();
    irq_in = 8'h00; cyc(1);
    wreg(2'd1, 8'h00);

    wreg(2'd1, 8'h04);
    irq_in = 8'h02; cyc(1);
    do_ack(8'h21, "R7 vector line 1");
    irq_in = 8'h42; cyc(1);
    chk_int(1'b1, "R7 lower line interrupts");
    do_ack(8'h26, "R7 vector line 6");
    do_rd(2'd2, 8'h42, "R7 isr two lines");
    eoi();
    do_rd(2'd2, 8'h40, "R5 eoi in special mask");
    eoi();
    irq_in = 8'h00; cyc(1);

    wreg(2'd1, 8'h06);
    irq_in = 8'h30; cyc(1);
    chk_int(1'b0, "R8 int stays low");
    ack = 1'b1; cyc(1); ack = 1'b0;
    do_rd(2'd0, 8'h84, "R8 poll line 4");
    do_rd(2'd2, 8'h10, "R8 poll acknowledges");
    do_rd(2'd0, 8'h85, "R8 poll line 5");
    do_rd(2'd0, 8'h00, "R8 poll empty");
    do_rd(2'd2, 8'h30, "R8 isr after polls");
    eoi(); eoi();
    do_rd(2'd2, 8'h00, "R5 cleared in poll");
    irq_in = 8'h00;

    cyc(3);
    chk(vq.size() == 0 && rq.size() == 0, "R2 all results seen",
        8'(vq.size() + rq.size()), 8'h00);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule